// File: doc/BRIEF.md
# SCL-Triggered Arbitration Glitch Injector

This block is a bus disturber for exercising the error handling of an I2C controller. Once armed with a microsecond count, it watches the clock line. On the next falling edge of SCL produced by the controller under test, it takes one of two actions. In pull mode it drives SDA low through an open-drain enable for exactly the programmed time. Any 1 bits the controller sends during that window are then read back as 0, so the controller should report lost arbitration. In event mode it counts the same programmed time and then raises a single-cycle fault event, which stands in for a sudden system failure partway through a transfer.

SCL is brought into the clock domain through a synchroniser before edge detection. A free-running microsecond prescaler is held in reset while the block is idle or armed, so the programmed time is counted in whole microseconds from the cycle the edge is taken. The block is one-shot: after each action it goes back to idle and does nothing until it is armed again. An abort input drops a pending arm before any edge arrives.

Top module: `scl_glitch_injector`

## Requirements
- R1: After reset both `sda_pull_o` and `fault_evt_o` are 0. In idle, falling edges on `scl_i` produce no activity.
- R2: With `mode_i`=0 (pull mode) armed, a fall of `scl_i` taken at a rising clock edge k asserts `sda_pull_o` from clock edge k+2. This counts two synchroniser stages and the control register.
- R3: In pull mode `sda_pull_o` stays high for exactly D×CLK_PER_US clock cycles, where D is the armed microsecond count.
- R4: An armed count above MAX_US is clamped to MAX_US.
- R5: With `mode_i`=1 (event mode) armed, `fault_evt_o` is high for exactly one cycle, D×CLK_PER_US cycles after edge k+2. `sda_pull_o` stays 0 throughout.
- R6: With D=0, event mode raises `fault_evt_o` in the cycle right after edge k+2, and pull mode never asserts `sda_pull_o`.
- R7: `abort_i` while armed returns the block to idle, so later SCL falls do nothing. If `abort_i` is high in the same cycle as `arm_i` or as a detected fall, `abort_i` wins.
- R8: After an action completes, the block does not re-trigger on later SCL falls until it is re-armed. While an action runs, `arm_i` and `abort_i` have no effect and the action runs to its full length.
- R9: Only a high-to-low transition of SCL triggers. A rising edge, or SCL that is already low when the block is armed, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Single-cycle arm request, accepted only in idle |
| mode_i | input | 1 | Action select: 0 = SDA pull, 1 = fault event |
| dur_us_i | input | DUR_W | Duration or delay in microseconds, latched at arm |
| abort_i | input | 1 | Cancels a pending arm |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_pull_o | output | 1 | Open-drain enable: 1 drives SDA low |
| fault_evt_o | output | 1 | Single-cycle fault event pulse |

## Verification
A control state that leaves idle too early shows up at once: `sda_pull_o` or `fault_evt_o` appears without an arm, or `sda_pull_o` rises at a cycle other than the third edge after SCL drops. A remaining-count or prescaler error shows up only when the action ends, as a pull window or event delay that is off by whole microseconds or single cycles. For that reason the bench compares every cycle of each window against the expected waveform. A state that fails to return to idle shows up on the next SCL fall, as a second action that was never armed.

// File: rtl/glitch_inj_pkg.sv
package glitch_inj_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PULL  = 2'd2,
        ST_WAIT  = 2'd3
    } inj_state_e;

    typedef enum logic {
        MODE_PULL  = 1'b0,
        MODE_EVENT = 1'b1
    } inj_mode_e;

    // Limit a requested microsecond count to the configured ceiling.
    function automatic logic [31:0] clamp_us(input logic [31:0] req, input logic [31:0] ceiling);
        return (req > ceiling) ? ceiling : req;
    endfunction

endpackage

// File: rtl/scl_fall_det.sv
module scl_fall_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], scl_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];

    // A fall indication is a single-cycle event per transition.
    AST_FALL_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o); // R9

endmodule

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CNT_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_PER_US - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST); // R3

endmodule

// File: rtl/glitch_ctrl.sv
module glitch_ctrl
    import glitch_inj_pkg::*;
#(
    parameter int          DUR_W  = 17,
    parameter int unsigned MAX_US = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             mode_i,
    input  logic [DUR_W-1:0] dur_i,
    input  logic             abort_i,
    input  logic             fall_i,
    input  logic             tick_i,
    output logic             tick_clr_o,
    output logic             sda_pull_o,
    output logic             fault_evt_o
);
    localparam logic [31:0]      MAX_L = 32'(MAX_US);
    localparam logic [DUR_W-1:0] MAX_V = DUR_W'(MAX_US);
    localparam logic [DUR_W-1:0] ONE   = DUR_W'(1);

    inj_state_e       state_q;
    inj_mode_e        mode_q;
    logic [DUR_W-1:0] remain_q;
    logic [DUR_W-1:0] dur_clamped;

    assign dur_clamped = DUR_W'(clamp_us(32'(dur_i), MAX_L));
    // Prescaler phase is held at zero until an action begins.
    assign tick_clr_o  = (state_q == ST_IDLE) || (state_q == ST_ARMED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            mode_q      <= MODE_PULL;
            remain_q    <= '0;
            sda_pull_o  <= 1'b0;
            fault_evt_o <= 1'b0;
        end else begin
            fault_evt_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (arm_i && !abort_i) begin
                        state_q  <= ST_ARMED;
                        mode_q   <= inj_mode_e'(mode_i);
                        remain_q <= dur_clamped;
                    end
                end
                ST_ARMED: begin
                    if (abort_i) begin
                        state_q <= ST_IDLE;
                    end else if (fall_i) begin
                        if (remain_q == '0) begin
                            fault_evt_o <= (mode_q == MODE_EVENT);
                            state_q     <= ST_IDLE;
                        end else if (mode_q == MODE_PULL) begin
                            sda_pull_o <= 1'b1;
                            state_q    <= ST_PULL;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_PULL: begin
                    if (tick_i) begin
                        remain_q <= remain_q - ONE;
                        if (remain_q == ONE) begin
                            sda_pull_o <= 1'b0;
                            state_q    <= ST_IDLE;
                        end
                    end
                end
                ST_WAIT: begin
                    if (tick_i) begin
                        remain_q <= remain_q - ONE;
                        if (remain_q == ONE) begin
                            fault_evt_o <= 1'b1;
                            state_q     <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_PULL_START: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> ($past(fall_i) && $past(state_q == ST_ARMED))); // R2

    AST_CLAMP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> (remain_q <= MAX_V)); // R4

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fault_evt_o |=> !fault_evt_o); // R5

    AST_WAIT_NO_PULL: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> !sda_pull_o); // R5

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED && abort_i) |=> (state_q == ST_IDLE && !sda_pull_o && !fault_evt_o)); // R7

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !arm_i) |=> (state_q == ST_IDLE && !sda_pull_o)); // R8

endmodule

// File: rtl/scl_glitch_injector.sv
module scl_glitch_injector #(
    parameter int          CLK_PER_US  = 50,
    parameter int unsigned MAX_US      = 100000,
    parameter int          DUR_W       = 17,
    parameter int          SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             mode_i,
    input  logic [DUR_W-1:0] dur_us_i,
    input  logic             abort_i,
    input  logic             scl_i,
    output logic             sda_pull_o,
    output logic             fault_evt_o
);
    logic fall_w;
    logic tick_w;
    logic tick_clr_w;

    scl_fall_det #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_fall (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .fall_o(fall_w)
    );

    us_tick_gen #(
        .CLK_PER_US(CLK_PER_US)
    ) u_tick (
        .clk   (clk),
        .rst   (rst),
        .clr_i (tick_clr_w),
        .tick_o(tick_w)
    );

    glitch_ctrl #(
        .DUR_W (DUR_W),
        .MAX_US(MAX_US)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .arm_i      (arm_i),
        .mode_i     (mode_i),
        .dur_i      (dur_us_i),
        .abort_i    (abort_i),
        .fall_i     (fall_w),
        .tick_i     (tick_w),
        .tick_clr_o (tick_clr_w),
        .sda_pull_o (sda_pull_o),
        .fault_evt_o(fault_evt_o)
    );

    AST_OUTPUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(sda_pull_o && fault_evt_o)); // R5

endmodule

// File: tb/scl_glitch_injector_test.sv
module scl_glitch_injector_test;
    localparam int CLK_PERIOD = 10;
    localparam int P    = 4;
    localparam int MAXU = 20;
    localparam int DW   = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arm = 1'b0;
    logic          mode = 1'b0;
    logic [DW-1:0] dur = '0;
    logic          abort = 1'b0;
    logic          scl = 1'b1;
    logic          sda_pull;
    logic          fault_evt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    scl_glitch_injector #(
        .CLK_PER_US (P),
        .MAX_US     (MAXU),
        .DUR_W      (DW),
        .SYNC_STAGES(2)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .arm_i      (arm),
        .mode_i     (mode),
        .dur_us_i   (dur),
        .abort_i    (abort),
        .scl_i      (scl),
        .sda_pull_o (sda_pull),
        .fault_evt_o(fault_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_bit(input string tag, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: %s actual=%b expected=%b", tag, what, got, exp);
        end
    endtask

    task automatic do_arm(input logic m, input int d);
        @(negedge clk);
        arm  = 1'b1;
        mode = m;
        dur  = DW'(d);
        @(negedge clk);
        arm  = 1'b0;
    endtask

    // Drop SCL and compare both outputs on every cycle of the window.
    // Sample j is taken after the j-th rising edge following the drop.
    task automatic run_window(input string tag, input int start, input int plen, input int evt_at,
                              input int total, input int inj_at, input int inj_kind);
        int bad_p = 0;
        int bad_e = 0;
        int at_p = 0;
        int at_e = 0;
        logic got_p = 1'b0;
        logic got_e = 1'b0;
        logic ex_p;
        logic ex_e;
        @(negedge clk);
        scl = 1'b0;
        for (int j = 1; j <= total; j++) begin
            @(negedge clk);
            arm   = 1'b0;
            abort = 1'b0;
            ex_p = (j >= start) && (j < start + plen);
            ex_e = (evt_at != 0) && (j == evt_at);
            if (sda_pull !== ex_p && bad_p == 0) begin
                bad_p = 1; at_p = j; got_p = sda_pull;
            end
            if (fault_evt !== ex_e && bad_e == 0) begin
                bad_e = 1; at_e = j; got_e = fault_evt;
            end
            if (j == inj_at) begin
                if (inj_kind == 1) arm = 1'b1;
                if (inj_kind == 2) abort = 1'b1;
            end
        end
        arm   = 1'b0;
        abort = 1'b0;
        checks++;
        if (bad_p != 0) begin
            errors++;
            $display("FAIL %s: sda_pull at sample %0d actual=%b expected=%b", tag, at_p, got_p, ~got_p);
        end
        checks++;
        if (bad_e != 0) begin
            errors++;
            $display("FAIL %s: fault_evt at sample %0d actual=%b expected=%b", tag, at_e, got_e, ~got_e);
        end
        scl = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check_bit("R1", "sda_pull in reset", sda_pull, 1'b0);
        check_bit("R1", "fault_evt in reset", fault_evt, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R1", "sda_pull after reset", sda_pull, 1'b0);
        run_window("R1 idle fall", 0, 0, 0, 12, 0, 0);
    endtask

    task automatic test_pull();
        do_arm(1'b0, 3);
        run_window("R2 R3 pull 3us", 3, 3*P, 0, 3*P + 8, 0, 0);
        do_arm(1'b0, 1);
        run_window("R3 pull 1us", 3, P, 0, P + 8, 0, 0);
    endtask

    task automatic test_clamp();
        do_arm(1'b0, 31);
        run_window("R4 clamp", 3, MAXU*P, 0, MAXU*P + 12, 0, 0);
    endtask

    task automatic test_event();
        do_arm(1'b1, 2);
        run_window("R5 event 2us", 0, 0, 3 + 2*P, 2*P + 10, 0, 0);
    endtask

    task automatic test_zero();
        do_arm(1'b1, 0);
        run_window("R6 event zero", 0, 0, 3, 10, 0, 0);
        do_arm(1'b0, 0);
        run_window("R6 pull zero", 0, 0, 0, 10, 0, 0);
    endtask

    task automatic test_abort();
        do_arm(1'b0, 2);
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        run_window("R7 abort armed", 0, 0, 0, 14, 0, 0);
        @(negedge clk);
        arm = 1'b1; abort = 1'b1; mode = 1'b0; dur = DW'(2);
        @(negedge clk);
        arm = 1'b0; abort = 1'b0;
        run_window("R7 abort with arm", 0, 0, 0, 14, 0, 0);
        // Abort coinciding with the fall: sample 2 drives abort for the k+2 edge.
        do_arm(1'b0, 2);
        run_window("R7 abort with fall", 0, 0, 0, 14, 2, 2);
    endtask

    task automatic test_one_shot();
        do_arm(1'b0, 2);
        run_window("R8 first pull", 3, 2*P, 0, 2*P + 6, 0, 0);
        run_window("R8 no retrigger", 0, 0, 0, 14, 0, 0);
        // Arm pulsed mid-pull is ignored; following fall does nothing.
        mode = 1'b0; dur = DW'(2);
        do_arm(1'b0, 2);
        run_window("R8 arm during pull", 3, 2*P, 0, 2*P + 6, 5, 1);
        run_window("R8 after ignored arm", 0, 0, 0, 14, 0, 0);
        // Abort pulsed mid-pull leaves the window at full length.
        do_arm(1'b0, 2);
        run_window("R8 abort during pull", 3, 2*P, 0, 2*P + 6, 5, 2);
    endtask

    task automatic test_edge_only();
        int bad = 0;
        @(negedge clk);
        scl = 1'b0;
        repeat (5) @(negedge clk);
        do_arm(1'b0, 1);
        repeat (4) @(negedge clk);
        scl = 1'b1;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            if (sda_pull !== 1'b0) bad = 1;
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL R9: pull on low level or rising edge actual=1 expected=0");
        end
        run_window("R9 later fall", 3, P, 0, P + 8, 0, 0);
    endtask

    initial begin
        test_reset();
        test_pull();
        test_clamp();
        test_event();
        test_zero();
        test_abort();
        test_one_shot();
        test_edge_only();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule